// File: doc/BRIEF.md
# Periodic Interval Timer

The block counts down a 16-bit value at a programmable fraction of the system clock and raises an interrupt flag each time the count runs out. Software configures it through three word registers on a simple strobe interface: a control/status word, a modulus word and a read-only count word. The tick rate is the system clock divided by two and then by a power of two selected by a 4-bit prescale field.

On running out, the count either restarts from the modulus (reload mode) or from all ones (free mode). A control write that only changes the interrupt enable or acknowledges the flag leaves the count running. Any other control change restarts it. A modulus write can either take effect at the next reload or, with the overwrite bit set, replace the count immediately.

Top module: `intv_timer`

## Requirements
- R1: After reset the control and modulus words read 0x0000, the count reads 0xFFFF and `irq` is low.
- R2: Control bit 0 (enable) gates counting. With it clear the count holds its value indefinitely.
- R3: The count drops by one every 2^(PRE+1) clocks, where PRE is control bits 11:8. The first decrement comes 2^(PRE+1) clocks after the edge that restarted the count.
- R4: A tick that finds the count at zero sets control bit 2 (flag) and does not wrap. It loads the modulus when control bit 1 (reload) is 1 and 0xFFFF when it is 0.
- R5: Writing 1 to control bit 2 clears the flag. Writing 0 keeps it, and no write can set it. An expiry in the same cycle as a clear leaves the flag set.
- R6: `irq` is high exactly when the flag and control bit 3 (interrupt enable) are both 1, starting in the same cycle the flag or enable changes.
- R7: A control write that differs from the stored word only in bits 3 or 2 leaves the count and the tick phase untouched. Any other difference restarts the count: it loads the limit chosen by the new reload bit and resets the tick phase. A restart also suppresses an expiry in that cycle.
- R8: Any write to the modulus word (byte offset 2) clears the flag.
- R9: With control bit 4 (overwrite) set, a modulus write loads the value into the count at once and resets the tick phase. With it clear, the count is untouched and the new modulus is used at the next reload.
- R10: Byte offset 0 reads the control word, offset 2 the modulus and offset 4 the live count. Writes to offset 4 are ignored, and other offsets read 0. Read data appears on `rdata` on the clock after `rd_en`.
- R11: Control bits 5 and 6 are stored and read back but change nothing. Bits 7 and 15:12 read 0, and writing them alone causes no restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| rd_en | input | 1 | Read strobe; data follows one clock later |
| addr | input | 3 | Byte offset of the word |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench builds the block with its defaults: a 16-bit count, a 3-bit offset and a fixed divide-by-two ahead of the prescaler. With these values a reload period of a few ticks at PRE 0 lasts only tens of clocks. Expiry, reload, free-mode wrap to 0xFFFF and the overlap of a restart with an expiry can therefore all be hit on exact cycles. PRE 3 checks the rate scaling over several periods. PRE 15 checks that the largest divider is decoded without overflow, which shows as a count still holding after a hundred clocks.

// File: rtl/intv_timer_pkg.sv
package intv_timer_pkg;
  localparam int DATA_W   = 16;
  localparam int PRE_W    = 4;
  localparam int OFF_CTRL = 0;
  localparam int OFF_MOD  = 2;
  localparam int OFF_CNT  = 4;

  // control/status word; bit positions are software-visible
  typedef struct packed {
    logic [3:0]       rsv_hi;
    logic [PRE_W-1:0] pre;
    logic             rsv7;
    logic             doze;
    logic             dbg;
    logic             ovw;
    logic             ie;
    logic             flag;
    logic             rld;
    logic             en;
  } ctrl_t;

  localparam logic [DATA_W-1:0] CTRL_KEEP = 16'h0F7F;  // stored bits
  localparam logic [DATA_W-1:0] CTRL_SOFT = 16'h000C;  // ie and flag: no restart
endpackage

// File: rtl/intv_timer_prescale.sv
module intv_timer_prescale #(
  parameter int PRE_W       = 4,
  parameter int SYS_DIV_LOG = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             phase_rst,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int MAX_EXP = SYS_DIV_LOG + (1 << PRE_W) - 1;
  localparam int DIV_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W:0]   full;
  logic [DIV_W-1:0] span;

  always_comb begin
    full = ((DIV_W+1)'(1) << (SYS_DIV_LOG + int'(pre))) - (DIV_W+1)'(1);
    span = full[DIV_W-1:0];
  end

  assign tick = en && (div_q == span);

  always_ff @(posedge clk) begin
    if (rst || phase_rst) begin
      div_q <= '0;
    end else if (en) begin
      div_q <= tick ? '0 : div_q + DIV_W'(1);
    end
  end

  generate
    if (SYS_DIV_LOG > 0) begin : g_gap
      // R3
      tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/intv_timer_counter.sv
module intv_timer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic at_zero;
  assign at_zero = (cnt_q == '0);
  assign expire  = tick && at_zero && !load;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (tick) begin
      cnt_q <= at_zero ? limit : cnt_q - CNT_W'(1);
    end
  end

  // R3
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !load && !at_zero) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    expire |=> cnt_q == $past(limit));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/intv_timer_regs.sv
module intv_timer_regs
  import intv_timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              expire,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  mod_q,
  output logic              cnt_load,
  output logic [CNT_W-1:0]  cnt_load_val,
  output logic              irq_q
);
  logic              wr_ctrl, wr_mod, restart, flag_clr, flag_nx;
  logic [DATA_W-1:0] ctrl_bits, wr_bits;
  ctrl_t             wr_val, ctrl_nx;

  assign wr_ctrl   = wr_en && (addr == ADDR_W'(OFF_CTRL));
  assign wr_mod    = wr_en && (addr == ADDR_W'(OFF_MOD));
  assign ctrl_bits = ctrl_q;
  assign wr_bits   = wdata & CTRL_KEEP;
  assign wr_val    = ctrl_t'(wr_bits);
  assign restart   = wr_ctrl && (((wr_bits ^ ctrl_bits) & ~CTRL_SOFT) != '0);
  assign flag_clr  = (wr_ctrl && wdata[2]) || wr_mod;
  assign flag_nx   = (ctrl_q.flag && !flag_clr) || expire;
  assign cnt_load  = restart || (wr_mod && ctrl_q.ovw);

  always_comb begin
    ctrl_nx = ctrl_q;
    if (wr_ctrl) ctrl_nx = wr_val;
    ctrl_nx.flag = flag_nx;
    if (restart) begin
      cnt_load_val = wr_val.rld ? mod_q : {CNT_W{1'b1}};
    end else begin
      cnt_load_val = wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mod_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_nx;
      irq_q  <= ctrl_nx.flag && ctrl_nx.ie;
      if (wr_mod) mod_q <= wdata[CNT_W-1:0];
    end
  end

  // R6
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ctrl_q.flag && ctrl_q.ie));
  // R5
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_q.flag) |-> $past(expire));
  // R8
  mod_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_mod && !expire) |=> !ctrl_q.flag);
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int ADDR_W      = 3,
  parameter int SYS_DIV_LOG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  output logic [15:0]       rdata,
  output logic              irq
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] mod_q, cnt_q, load_val, limit;
  logic             cnt_load, tick, expire;

  intv_timer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .expire(expire), .ctrl_q(ctrl_q), .mod_q(mod_q), .cnt_load(cnt_load),
    .cnt_load_val(load_val), .irq_q(irq)
  );

  intv_timer_prescale #(.PRE_W(PRE_W), .SYS_DIV_LOG(SYS_DIV_LOG)) pre_i (
    .clk(clk), .rst(rst), .en(ctrl_q.en), .phase_rst(cnt_load),
    .pre(ctrl_q.pre), .tick(tick)
  );

  assign limit = ctrl_q.rld ? mod_q : {CNT_W{1'b1}};

  intv_timer_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk(clk), .rst(rst), .tick(tick), .load(cnt_load), .load_val(load_val),
    .limit(limit), .cnt_q(cnt_q), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      if (addr == ADDR_W'(OFF_CTRL))     rdata <= ctrl_q;
      else if (addr == ADDR_W'(OFF_MOD)) rdata <= DATA_W'(mod_q);
      else if (addr == ADDR_W'(OFF_CNT)) rdata <= DATA_W'(cnt_q);
      else                               rdata <= '0;
    end
  end

  // R10
  cnt_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(OFF_CNT)) |=> rdata == DATA_W'($past(cnt_q)));
endmodule

// File: tb/intv_timer_tb_top.sv
`timescale 1ns/1ps
module intv_timer_tb_top;
  logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int     n_run = 0, n_fail = 0;
  longint cyc = 0, last_edge = 0;
  longint b_e0 = 0, b_d = 2, b_l = 0;
  bit     b_en = 1'b0;
  logic   mon_pend = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb_q[$];

  intv_timer dut_i (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
                    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    mon_pend <= rd_en;
  end

  // monitor: compares each read result against the scoreboard head
  always @(negedge clk) begin
    if (mon_pend) begin
      item_t it;
      n_run++;
      if (sb_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual %h expected none", rdata);
      end else begin
        it = sb_q.pop_front();
        if (rdata !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    last_edge = cyc + 1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    sb_q.push_back('{e, tag});
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic base(input longint l, input longint d, input bit en);
    b_e0 = last_edge; b_l = l; b_d = d; b_en = en;
  endtask

  function automatic logic [15:0] exp_cnt();
    longint w = cyc - b_e0;
    if (!b_en) return 16'(b_l);
    return 16'(b_l - ((w / b_d) % (b_l + 1)));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] got,
                     input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wait_to(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_up();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    longint ex;
    @(negedge clk);
    wait_n(4);
    rst = 1'b0;
    // R1 reset state
    chk(irq == 1'b0, "R1 irq after reset", 16'(irq), 16'h0);
    rd(3'd0, 16'h0000, "R1 ctrl reset");
    rd(3'd2, 16'h0000, "R1 modulus reset");
    rd(3'd4, 16'hFFFF, "R1 count reset");

    // R3 reload mode, PRE 0
    wr(3'd2, 16'd5);
    wr(3'd0, 16'h0003); base(5, 2, 1'b1);
    wait_n(3);
    rd(3'd4, exp_cnt(), "R3 count rate");
    // R4 expiry reloads modulus and sets flag
    wait_to(b_e0 + 12);
    rd(3'd4, exp_cnt(), "R4 reload from modulus");
    rd(3'd0, 16'h0007, "R4 flag set on expiry");
    chk(irq == 1'b0, "R6 irq masked", 16'(irq), 16'h0);
    // R6/R7 enabling interrupts only
    wr(3'd0, 16'h000B);
    chk(irq == 1'b1, "R6 irq on enable", 16'(irq), 16'h1);
    rd(3'd4, exp_cnt(), "R7 count kept on ie write");
    rd(3'd0, 16'h000F, "R5 write 0 keeps flag");
    wr(3'd0, 16'h000F);
    chk(irq == 1'b0, "R5 W1C drops irq", 16'(irq), 16'h0);
    rd(3'd0, 16'h000B, "R5 flag cleared");
    rd(3'd4, exp_cnt(), "R7 count kept on flag clear");
    wr(3'd0, 16'h000F);
    rd(3'd0, 16'h000B, "R5 write cannot set flag");
    rd(3'd4, exp_cnt(), "R7 count kept");
    // R7 restart coinciding with expiry; R2 disabled hold
    wr(3'd0, 16'h0002); base(5, 2, 1'b0);
    rd(3'd0, 16'h0002, "R7 restart suppresses expiry");
    wait_n(10);
    rd(3'd4, exp_cnt(), "R2 disabled count holds");

    // R8 modulus write clears flag, R9 deferred modulus
    wr(3'd0, 16'h000B); base(5, 2, 1'b1);
    wait_to(b_e0 + 12);
    chk(irq == 1'b1, "R6 irq follows flag", 16'(irq), 16'h1);
    wr(3'd2, 16'd3);
    chk(irq == 1'b0, "R8 modulus write clears flag", 16'(irq), 16'h0);
    rd(3'd0, 16'h000B, "R8 flag clear in ctrl");
    rd(3'd4, exp_cnt(), "R9 count untouched without overwrite");
    ex = b_e0 + 24;
    wait_to(ex + 3);
    last_edge = ex; base(3, 2, 1'b1);
    rd(3'd4, exp_cnt(), "R9 new modulus at next reload");

    // R9 overwrite
    wr(3'd0, 16'h001B); base(3, 2, 1'b1);
    wait_n(5);
    wr(3'd2, 16'd9); base(9, 2, 1'b1);
    wait_n(4);
    rd(3'd4, exp_cnt(), "R9 overwrite loads count");
    rd(3'd2, 16'd9, "R9 modulus stored");

    // R4 free mode
    wr(3'd0, 16'h0001); base(16'hFFFF, 2, 1'b1);
    wait_n(10);
    rd(3'd4, exp_cnt(), "R4 free mode from FFFF");
    wr(3'd0, 16'h0011);
    wr(3'd2, 16'd4); base(4, 2, 1'b1);
    wait_n(4);
    rd(3'd4, exp_cnt(), "R9 free overwrite");
    wait_to(b_e0 + 10);
    rd(3'd4, 16'hFFFF, "R4 free mode wraps to FFFF");
    rd(3'd0, 16'h0015, "R4 flag in free mode");
    rd(3'd4, 16'hFFFE, "R4 free mode continues");

    // R3 prescaler
    wr(3'd0, 16'h0303); base(4, 16, 1'b1);
    wr(3'd0, 16'h0307);
    rd(3'd0, 16'h0303, "R5 W1C at PRE 3");
    wait_to(b_e0 + 40);
    rd(3'd4, exp_cnt(), "R3 PRE 3 rate");
    wait_to(b_e0 + 80);
    rd(3'd0, 16'h0307, "R3 PRE 3 expiry time");
    wr(3'd0, 16'h0F03); base(4, 65536, 1'b1);
    wait_n(100);
    rd(3'd4, exp_cnt(), "R3 PRE 15 slow");

    // R10 address map
    wr(3'd4, 16'h1234);
    rd(3'd4, exp_cnt(), "R10 count write ignored");
    rd(3'd2, 16'd4, "R10 modulus unchanged");
    rd(3'd0, 16'h0F07, "R10 ctrl unchanged");
    rd(3'd6, 16'h0000, "R10 unmapped reads zero");

    // R11 inert bits
    wr(3'd0, 16'h0067); base(4, 2, 1'b1);
    rd(3'd0, 16'h0063, "R11 debug/doze stored");
    wr(3'd0, 16'hF0E3);
    rd(3'd0, 16'h0063, "R11 unused bits read zero");
    rd(3'd4, exp_cnt(), "R11 no restart, count unaffected");
    wait_n(3);
    rd(3'd4, exp_cnt(), "R11 count runs with debug/doze set");

    wait_n(3);
    chk(sb_q.size() == 0, "R10 all reads answered", 16'(sb_q.size()), 16'h0);
    finish_up();
  end
endmodule